// File: doc/BRIEF.md
# Byte-Wide SPI Master Shift Engine

This block sends and receives one byte at a time over a three-wire SPI link. Software writes a byte into a single data buffer. The engine then produces sixteen SCK half periods, shifting the byte out on SDO with the most significant bit first. At the same time it shifts the incoming SDI bits into the same register. When the last half period ends, a buffer-full flag and an interrupt flag are raised, and the received byte can be read from the buffer port.

The bit clock has two sources:
- a fixed division of the system clock (`SYS_DIV`, so each SCK half lasts `SYS_DIV/2` cycles);
- a free-running timer tick, where each half lasts one tick interval, so the bit rate is half the tick rate.

A transfer started from the tick source waits for the next tick before its first half begins. The first SCK pulse is therefore never shortened by the tick phase at the moment of the write.

Clock polarity and clock phase are selectable. A buffer write that arrives while a shift is under way is discarded and latches a collision flag. An enable input aborts or blocks transfers, and it never pulls SCK away from its idle level.

Top module: `spi_shift_master`

## Requirements
- R1: After reset, `full_o`, `irq_o` and `wcol_o` are 0, `rdata_o` is 0, and `sck_o` equals `cpol_i`.
- R2: With `clk_src_i`=0, a write accepted at a clock edge starts the first SCK half at that edge. Each of the 16 halves lasts exactly `SYS_DIV/2` cycles, so completion falls `8*SYS_DIV` cycles after the write edge.
- R3: With `clk_src_i`=1, SCK stays at its idle level after the write until the first edge at which `tick_i` is 1. From then on each half spans from one tick to the next.
- R4: While idle, `sck_o` equals `cpol_i`. In the first half of each bit `sck_o` is `cpol_i ^ cpha_i`, and in the second half it is the inverse. SDI is sampled at the edge between the two halves of a bit. SDO moves to the next bit at the edge that ends the second half.
- R5: Data leaves MSB first. `sdo_o` shows bit 7 of the written byte from the cycle after the write, and bit 7-k during bit k.
- R6: At the edge that ends the sixteenth half, `full_o` and `irq_o` are set, `sck_o` returns to `cpol_i`, and `rdata_o` holds the received byte.
- R7: A pulse on `rd_i` clears `full_o` and leaves `irq_o` set. Only `irq_clr_i` clears `irq_o`.
- R8: A write while a transfer is armed or shifting sets `wcol_o`. The written byte is discarded, and the running transfer completes with its original data and timing.
- R9: `wcol_o` stays set through later transfers until `wcol_clr_i` is pulsed. A write made after clearing it, while idle, starts a normal transfer.
- R10: While `en_i` is 0, writes are ignored: no transfer starts and no flag changes. Toggling `en_i` while idle keeps `sck_o` at `cpol_i` in every cycle. Dropping `en_i` mid-transfer aborts it with `sck_o` at `cpol_i` from the next edge, and no completion flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Module enable |
| cpol_i | input | 1 | SCK idle level |
| cpha_i | input | 1 | 1: SCK toggles at the start of each bit |
| clk_src_i | input | 1 | 0: divided system clock, 1: timer tick |
| tick_i | input | 1 | Timer period-match pulse, one cycle wide |
| wr_i | input | 1 | Buffer write strobe |
| wdata_i | input | DATA_W | Byte to transmit |
| rd_i | input | 1 | Buffer read strobe, clears buffer-full |
| irq_clr_i | input | 1 | Clears the completion interrupt flag |
| wcol_clr_i | input | 1 | Clears the write-collision flag |
| rdata_o | output | DATA_W | Buffer contents, received byte when full |
| full_o | output | 1 | Buffer-full flag |
| irq_o | output | 1 | Completion interrupt flag |
| wcol_o | output | 1 | Write-collision flag |
| sck_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |

## Verification
The hardest situation to reach is a buffer write that lands between two timer ticks. This is the case where a naive design would emit a short first SCK half. The bench runs the tick as a free-running counter that is independent of the write schedule, so writes fall at many tick phases. It then follows the expected waveform cycle by cycle from the tick sequence it drives itself. The mid-transfer collision write, the abort by disable and the enable toggling with idle-high polarity are placed at fixed cycle offsets after a write. SCK and the flags are checked in every cycle around each of them.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_SHIFT = 2'd2
  } xfer_state_e;

  typedef enum logic {
    SRC_SYSDIV = 1'b0,
    SRC_TICK   = 1'b1
  } clk_src_e;
endpackage

// File: rtl/spi_bit_timer.sv
module spi_bit_timer
  import spi_master_pkg::*;
#(
  parameter int SYS_DIV = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic src_i,
  input  logic tick_i,
  output logic adv_o
);
  localparam int HALF = SYS_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic sys_adv;

  generate
    if (HALF <= 1) begin : g_nodiv
      assign sys_adv = run_i;
    end else begin : g_div
      logic [CW-1:0] cnt_q;
      logic          wrap;
      assign wrap = (cnt_q == CW'(HALF - 1));
      // counter restarts whenever the shifter is not running
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              cnt_q <= '0;
        else if (!run_i || wrap)  cnt_q <= '0;
        else                      cnt_q <= cnt_q + 1'b1;
      end
      assign sys_adv = run_i && wrap;
    end
  endgenerate

  assign adv_o = (clk_src_e'(src_i) == SRC_TICK) ? tick_i : sys_adv;
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              sample_i,
  input  logic              shift_i,
  input  logic              sdi_i,
  output logic [DATA_W-1:0] data_o,
  output logic              msb_o
);
  logic [DATA_W-1:0] sh_q;
  logic              smp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      smp_q <= 1'b0;
    end else begin
      if (load_i)        sh_q <= load_data_i;
      else if (shift_i)  sh_q <= {sh_q[DATA_W-2:0], smp_q};
      if (sample_i)      smp_q <= sdi_i;
    end
  end

  assign data_o = sh_q;
  assign msb_o  = sh_q[DATA_W-1];
endmodule

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
  import spi_master_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic cpol_i,
  input  logic cpha_i,
  input  logic src_i,
  input  logic wr_i,
  input  logic rd_i,
  input  logic irq_clr_i,
  input  logic wcol_clr_i,
  input  logic adv_i,
  output logic run_o,
  output logic load_o,
  output logic sample_o,
  output logic shift_o,
  output logic sck_o,
  output logic busy_o,
  output logic armed_o,
  output logic full_o,
  output logic irq_o,
  output logic wcol_o
);
  localparam int HALVES = 2 * DATA_W;
  localparam int HW     = $clog2(HALVES);

  xfer_state_e   state_q, state_d;
  logic [HW-1:0] half_q;
  logic          sck_q, full_q, irq_q, wcol_q;
  logic          lead, accept, collide, second_half, last_half, done, in_shift;

  assign lead        = cpol_i ^ cpha_i;
  assign in_shift    = (state_q == ST_SHIFT);
  assign accept      = wr_i && en_i && (state_q == ST_IDLE);
  assign collide     = wr_i && en_i && (state_q != ST_IDLE);
  assign second_half = half_q[0];
  assign last_half   = (half_q == HW'(HALVES - 1));
  assign sample_o    = in_shift && en_i && adv_i && !second_half;
  assign shift_o     = in_shift && en_i && adv_i && second_half;
  assign done        = shift_o && last_half;
  assign load_o      = accept;
  assign run_o       = in_shift;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept)
                 state_d = (clk_src_e'(src_i) == SRC_TICK) ? ST_ARM : ST_SHIFT;
      ST_ARM:  if (!en_i) state_d = ST_IDLE;
               else if (adv_i) state_d = ST_SHIFT;
      ST_SHIFT: if (!en_i || done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      half_q  <= '0;
      sck_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_d == ST_SHIFT && !in_shift) begin
        half_q <= '0;
        sck_q  <= lead;
      end else if (sample_o) begin
        half_q <= half_q + 1'b1;
        sck_q  <= ~lead;
      end else if (shift_o && !last_half) begin
        half_q <= half_q + 1'b1;
        sck_q  <= lead;
      end
    end
  end

  // set wins over clear on every flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      irq_q  <= 1'b0;
      wcol_q <= 1'b0;
    end else begin
      if (done)            full_q <= 1'b1;
      else if (rd_i)       full_q <= 1'b0;
      if (done)            irq_q  <= 1'b1;
      else if (irq_clr_i)  irq_q  <= 1'b0;
      if (collide)         wcol_q <= 1'b1;
      else if (wcol_clr_i) wcol_q <= 1'b0;
    end
  end

  // outside the shift phase the pin follows the idle level directly
  assign sck_o   = in_shift ? sck_q : cpol_i;
  assign busy_o  = (state_q != ST_IDLE);
  assign armed_o = (state_q == ST_ARM);
  assign full_o  = full_q;
  assign irq_o   = irq_q;
  assign wcol_o  = wcol_q;
endmodule

// File: rtl/spi_shift_master.sv
module spi_shift_master #(
  parameter int DATA_W  = 8,
  parameter int SYS_DIV = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              clk_src_i,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  input  logic              irq_clr_i,
  input  logic              wcol_clr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              full_o,
  output logic              irq_o,
  output logic              wcol_o,
  output logic              sck_o,
  output logic              sdo_o,
  input  logic              sdi_i
);
  logic run, adv, load, sample, shift, busy, armed;

  spi_bit_timer #(.SYS_DIV(SYS_DIV)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .src_i  (clk_src_i),
    .tick_i (tick_i),
    .adv_o  (adv)
  );

  spi_xfer_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .cpol_i     (cpol_i),
    .cpha_i     (cpha_i),
    .src_i      (clk_src_i),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .irq_clr_i  (irq_clr_i),
    .wcol_clr_i (wcol_clr_i),
    .adv_i      (adv),
    .run_o      (run),
    .load_o     (load),
    .sample_o   (sample),
    .shift_o    (shift),
    .sck_o      (sck_o),
    .busy_o     (busy),
    .armed_o    (armed),
    .full_o     (full_o),
    .irq_o      (irq_o),
    .wcol_o     (wcol_o)
  );

  spi_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_data_i (wdata_i),
    .sample_i    (sample),
    .shift_i     (shift),
    .sdi_i       (sdi_i),
    .data_o      (rdata_o),
    .msb_o       (sdo_o)
  );
endmodule

// File: rtl/spi_master_chk.sv
module spi_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic cpol_i,
  input logic wr_i,
  input logic rd_i,
  input logic irq_clr_i,
  input logic wcol_clr_i,
  input logic sck_o,
  input logic full_o,
  input logic irq_o,
  input logic wcol_o,
  input logic busy_i,
  input logic armed_i
);
  assert_disabled_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (sck_o == cpol_i));

  assert_armed_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_i |-> (sck_o == cpol_i));

  assert_collision_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && en_i && wr_i) |=> wcol_o);

  assert_done_flags_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o) |-> irq_o);

  assert_full_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(full_o) |-> $past(rd_i));

  assert_irq_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(irq_clr_i));

  assert_wcol_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wcol_o) |-> $past(wcol_clr_i));
endmodule

bind spi_shift_master spi_master_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .cpol_i     (cpol_i),
  .wr_i       (wr_i),
  .rd_i       (rd_i),
  .irq_clr_i  (irq_clr_i),
  .wcol_clr_i (wcol_clr_i),
  .sck_o      (sck_o),
  .full_o     (full_o),
  .irq_o      (irq_o),
  .wcol_o     (wcol_o),
  .busy_i     (busy),
  .armed_i    (armed)
);

// File: tb/tb_spi_shift_master.sv
`timescale 1ns/1ps
module tb_spi_shift_master;
  localparam int SYS_DIV = 64;
  localparam int HALF    = SYS_DIV / 2;
  localparam int TP      = 5;

  typedef struct packed {
    logic [7:0] data;
    logic       cpol;
    logic       cpha;
    logic       src;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'hA5, 1'b0, 1'b0, 1'b0},
    '{8'h3C, 1'b0, 1'b1, 1'b0},
    '{8'h81, 1'b1, 1'b0, 1'b0},
    '{8'h7E, 1'b1, 1'b1, 1'b0},
    '{8'h5A, 1'b0, 1'b0, 1'b1},
    '{8'hC3, 1'b0, 1'b1, 1'b1},
    '{8'h01, 1'b1, 1'b0, 1'b1},
    '{8'hF0, 1'b1, 1'b1, 1'b1}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic en_i = 1'b1, cpol_i = 1'b1, cpha_i = 1'b0, clk_src_i = 1'b0, tick_i = 1'b0;
  logic wr_i = 1'b0, rd_i = 1'b0, irq_clr_i = 1'b0, wcol_clr_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic full_o, irq_o, wcol_o, sck_o, sdo_o, sdi_i;
  int n_checks = 0, n_err = 0, tick_cnt = 0;

  always #2.5 clk = ~clk;
  assign sdi_i = sdo_o;

  spi_shift_master #(.DATA_W(8), .SYS_DIV(SYS_DIV)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .cpol_i(cpol_i), .cpha_i(cpha_i),
    .clk_src_i(clk_src_i), .tick_i(tick_i), .wr_i(wr_i), .wdata_i(wdata_i),
    .rd_i(rd_i), .irq_clr_i(irq_clr_i), .wcol_clr_i(wcol_clr_i), .rdata_o(rdata_o),
    .full_o(full_o), .irq_o(irq_o), .wcol_o(wcol_o), .sck_o(sck_o), .sdo_o(sdo_o),
    .sdi_i(sdi_i)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // one negedge step; tick is a free-running pulse every TP cycles
  task automatic cyc();
    @(negedge clk);
    tick_cnt = (tick_cnt + 1) % TP;
    tick_i = (tick_cnt == 0);
  endtask

  task automatic write_byte(input logic [7:0] d);
    wdata_i = d; wr_i = 1'b1;
    cyc();
    wr_i = 1'b0;
  endtask

  // full transfer with cycle-by-cycle waveform model; ends with flags cleared except wcol
  task automatic run_xfer(input logic [7:0] d, input logic pol, input logic pha, input logic src);
    int m_half = 0, m_cnt = 0, steps = 0, bad = 0, bad_act = 0, bad_exp = 0;
    bit started, adv;
    logic exp_sck, exp_sdo;
    cpol_i = pol; cpha_i = pha; clk_src_i = src;
    cyc();
    chk(sck_o === pol, "R4", "idle sck", sck_o, pol);
    write_byte(d);
    started = (src == 1'b0);
    while (m_half < 16 && steps < 5000) begin
      exp_sck = !started ? pol : ((m_half % 2 == 0) ? (pol ^ pha) : ~(pol ^ pha));
      exp_sdo = d[7 - m_half / 2];
      if (bad == 0 && (sck_o !== exp_sck || sdo_o !== exp_sdo || full_o !== 1'b0)) begin
        bad = steps + 1;
        bad_act = {full_o, sck_o, sdo_o};
        bad_exp = {1'b0, exp_sck, exp_sdo};
      end
      if (!started) begin
        if (tick_i) started = 1'b1;
      end else begin
        if (src) adv = tick_i;
        else begin
          adv = (m_cnt == HALF - 1);
          m_cnt = adv ? 0 : m_cnt + 1;
        end
        if (adv) m_half++;
      end
      cyc();
      steps++;
    end
    // waveform: R2 (sysdiv) / R3 (tick), levels R4, order R5
    chk(bad == 0, src ? "R3/R4/R5" : "R2/R4/R5", "waveform {full,sck,sdo}", bad_act, bad_exp);
    chk(full_o === 1'b1 && irq_o === 1'b1 && sck_o === pol, "R6", "done flags {full,irq,sck}",
        {full_o, irq_o, sck_o}, {2'b11, pol});
    chk(rdata_o === d, "R6", "loopback byte", rdata_o, d);
    rd_i = 1'b1; cyc(); rd_i = 1'b0;
    chk(full_o === 1'b0 && irq_o === 1'b1, "R7", "read clears full only", {full_o, irq_o}, 2'b01);
    irq_clr_i = 1'b1; cyc(); irq_clr_i = 1'b0;
    chk(irq_o === 1'b0, "R7", "irq clear", irq_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    int k;
    bit ok;
    repeat (3) cyc();
    rst_ni = 1'b1;
    cyc();
    // R1 reset state
    chk(full_o === 0 && irq_o === 0 && wcol_o === 0, "R1", "reset flags", {full_o, irq_o, wcol_o}, 0);
    chk(rdata_o === 8'h00 && sck_o === 1'b1, "R1", "reset data/sck", {rdata_o, sck_o}, 9'h001);

    for (int i = 0; i < 8; i++)
      run_xfer(VECS[i].data, VECS[i].cpol, VECS[i].cpha, VECS[i].src);

    // R8 collision mid-transfer
    cpol_i = 1'b0; cpha_i = 1'b0; clk_src_i = 1'b0;
    cyc();
    write_byte(8'h96);
    k = 0;
    while (full_o !== 1'b1 && k < 2000) begin
      if (k == 40) begin wr_i = 1'b1; wdata_i = 8'hFF; end
      else wr_i = 1'b0;
      cyc();
      k++;
      if (k == 41) chk(wcol_o === 1'b1, "R8", "collision flag", wcol_o, 1);
    end
    wr_i = 1'b0;
    chk(k == 16 * HALF, "R8", "completion timing after collision", k, 16 * HALF);
    chk(rdata_o === 8'h96, "R8", "original byte kept", rdata_o, 8'h96);
    rd_i = 1'b1; irq_clr_i = 1'b1; cyc(); rd_i = 1'b0; irq_clr_i = 1'b0;

    // R9 sticky collision flag, then clear and retry
    run_xfer(8'h4B, 1'b0, 1'b1, 1'b1);
    chk(wcol_o === 1'b1, "R9", "wcol sticky", wcol_o, 1);
    wcol_clr_i = 1'b1; cyc(); wcol_clr_i = 1'b0;
    chk(wcol_o === 1'b0, "R9", "wcol cleared", wcol_o, 0);
    run_xfer(8'hD2, 1'b0, 1'b0, 1'b0);
    chk(wcol_o === 1'b0, "R9", "no collision on rewrite", wcol_o, 0);

    // R10 enable toggling while idle with idle-high clock
    cpol_i = 1'b1; cpha_i = 1'b1; clk_src_i = 1'b0;
    ok = 1'b1;
    for (int j = 0; j < 12; j++) begin
      en_i = (j % 3 != 0);
      cyc();
      if (sck_o !== 1'b1) ok = 1'b0;
    end
    chk(ok, "R10", "sck idle-high across enable toggles", ok, 1);

    // R10 writes ignored while disabled
    en_i = 1'b0;
    write_byte(8'h55);
    ok = 1'b1;
    for (int j = 0; j < 3 * HALF; j++) begin
      if (sck_o !== 1'b1 || full_o !== 1'b0 || wcol_o !== 1'b0) ok = 1'b0;
      cyc();
    end
    chk(ok && rdata_o === 8'hD2, "R10", "disabled write ignored", rdata_o, 8'hD2);

    // R10 abort mid-transfer
    en_i = 1'b1;
    cyc();
    write_byte(8'h33);
    repeat (50) cyc();
    en_i = 1'b0;
    cyc();
    ok = 1'b1;
    for (int j = 0; j < 20 * HALF; j++) begin
      if (sck_o !== 1'b1 || full_o !== 1'b0 || irq_o !== 1'b0) ok = 1'b0;
      cyc();
    end
    chk(ok, "R10", "abort leaves sck idle, no completion", ok, 1);
    en_i = 1'b1;
    run_xfer(8'hE7, 1'b1, 1'b1, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule